// File: doc/BRIEF.md
# Programmable Divide-by-N Counter Slice

This block is a synchronous binary up-counter with a parallel data input, meant to be used either as a plain counter or as a clock-ratio divider. The count advances on each rising clock edge while the active-low count enable is low. It holds while that enable is high. A parallel-load strobe copies the data bus into the count register.

When the reload control is set, the slice does not wrap from all ones to zero. It fetches the data bus again on that edge. The count then runs from the loaded value P up to all ones and repeats, so the terminal flag pulses once every 256 − P enabled cycles at the default width. The reload path is inside the block, so division needs no external gating.

The terminal flag is active low and combinational from the count bits. It has the same polarity as the count enable, so the flag of a lower slice can drive the enable of the next slice directly.

Top module: `divCounter`

## Requirements
- R1: While rstN is low, count is 0 and tcN is 1; both keep these values on the first edges after release while no control is active.
- R2: tcN is 0 exactly when every bit of count is 1, and 1 for every other count value, in the same cycle as the count.
- R3: With loadEn=0, cntEnN=0 and reloadOnTc=0, count increases by one on each rising edge and wraps from 255 to 0.
- R4: With loadEn=0 and cntEnN=1, count keeps its value on the edge, whatever parIn and reloadOnTc are.
- R5: With loadEn=1, count takes the value of parIn on the next rising edge, whatever cntEnN is.
- R6: loadEn=1 takes priority over counting and over terminal reload: at count 255 with cntEnN=0 and reloadOnTc=1, the next count is parIn and not 0.
- R7: With loadEn=0, cntEnN=0, reloadOnTc=1 and count=255, the next count is parIn instead of 0.
- R8: reloadOnTc has no effect while count is below 255: with cntEnN=0 the count still increases by one.
- R9: With reloadOnTc=1, cntEnN=0 and a start value P, tcN goes low once every 256 − P edges (P=143 gives a period of 113).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low, clears the count |
| cntEnN | input | 1 | Count enable, active low |
| loadEn | input | 1 | Parallel load strobe, active high |
| reloadOnTc | input | 1 | Reload parIn on terminal count instead of wrapping |
| parIn | input | 8 | Parallel data / divider start value |
| count | output | 8 | Current count |
| tcN | output | 1 | Terminal-count flag, low when count is all ones |

## Verification
The assertions check every cycle that the flag tracks the all-ones state. They also check the one-edge effect of each control combination: hold, increment, explicit load, and reload at terminal count. What only the bench scenarios can show is the division ratio over whole periods: the spacing of successive flag pulses for a chosen start value, and the wrap from all ones to zero when reload is off. Random control mixes add coverage of the priority between the explicit load and the terminal reload.

// File: rtl/div_counter_pkg.sv
package div_counter_pkg;
  typedef struct packed {
    logic load;   // copy parallel input into the register
    logic inc;    // advance by one
  } cntStrobes_t;
endpackage

// File: rtl/cnt_ctrl.sv
module cntCtrl
  import div_counter_pkg::*;
(
  input  logic        loadEn,
  input  logic        cntEnN,
  input  logic        reloadOnTc,
  input  logic        atTerminal,
  output cntStrobes_t strobes
);
  logic enabled;
  logic tcReload;

  assign enabled  = ~cntEnN;
  assign tcReload = enabled & reloadOnTc & atTerminal;

  always_comb begin
    strobes = '0;
    if (loadEn) begin
      strobes.load = 1'b1;
    end else if (tcReload) begin
      strobes.load = 1'b1;
    end else if (enabled) begin
      strobes.inc = 1'b1;
    end
  end

  always_comb begin
    assert (!(strobes.load && strobes.inc)); // R6
  end
endmodule

// File: rtl/cnt_datapath.sv
module cntDatapath
  import div_counter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobes_t      strobes,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] count,
  output logic             atTerminal
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countD;

  always_comb begin
    countD = countQ;
    if (strobes.load) begin
      countD = parIn;
    end else if (strobes.inc) begin
      countD = countQ + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else begin
      countQ <= countD;
    end
  end

  assign count      = countQ;
  assign atTerminal = (countQ == ALL_ONES);

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> countQ == $past(parIn)); // R5

  AST_INC_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.inc && !strobes.load) |=> countQ == $past(countQ) + ONE); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.inc && !strobes.load) |=> $stable(countQ)); // R4
endmodule

// File: rtl/div_counter.sv
module divCounter
  import div_counter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEnN,
  input  logic             loadEn,
  input  logic             reloadOnTc,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] count,
  output logic             tcN
);
  cntStrobes_t strobes;
  logic        atTerminal;

  cntCtrl u_ctrl (
    .loadEn     (loadEn),
    .cntEnN     (cntEnN),
    .reloadOnTc (reloadOnTc),
    .atTerminal (atTerminal),
    .strobes    (strobes)
  );

  cntDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .parIn      (parIn),
    .count      (count),
    .atTerminal (atTerminal)
  );

  assign tcN = ~atTerminal;

  AST_TC_FLAG_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> (tcN == (count != {WIDTH{1'b1}}))); // R2

  AST_TC_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !cntEnN && reloadOnTc && !tcN) |=> count == $past(parIn)); // R7

  AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && !cntEnN) |=> count == $past(parIn)); // R6

  AST_HOLD_PORTS: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && cntEnN) |=> $stable(count)); // R4

  AST_NO_EARLY_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !cntEnN && tcN) |=> count == $past(count) + 1'b1); // R8
endmodule

// File: tb/sim_divCounter.sv
module sim_divCounter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntEnN = 1'b1;
  logic       loadEn = 1'b0;
  logic       reloadOnTc = 1'b0;
  logic [7:0] parIn = 8'h00;
  logic [7:0] count;
  logic       tcN;

  int checks = 0;
  int failures = 0;
  logic [7:0] expCount = 8'h00;
  bit done = 1'b0;

  always #10 clk = ~clk;

  divCounter u0 (
    .clk(clk), .rstN(rstN), .cntEnN(cntEnN), .loadEn(loadEn),
    .reloadOnTc(reloadOnTc), .parIn(parIn), .count(count), .tcN(tcN)
  );

  function automatic logic [7:0] nextCount(logic [7:0] cur, logic ld,
                                            logic enN, logic rl, logic [7:0] p);
    if (ld) return p;
    if (enN) return cur;
    if (rl && cur == 8'hFF) return p;
    return cur + 8'd1;
  endfunction

  function automatic string tagFor(logic [7:0] cur, logic ld, logic enN, logic rl);
    if (ld && !enN && rl && cur == 8'hFF) return "R6";
    if (ld) return "R5";
    if (enN) return "R4";
    if (rl && cur == 8'hFF) return "R7";
    if (rl) return "R8";
    return "R3";
  endfunction

  task automatic check(string tag, logic [7:0] expC);
    logic expTc;
    expTc = (expC != 8'hFF);
    checks++;
    if (count !== expC || tcN !== expTc) begin
      failures++;
      $display("FAIL %s count=%0d tcN=%b expected count=%0d tcN=%b",
               tag, count, tcN, expC, expTc);
    end
  endtask

  // drive at negedge, apply one edge, check at the following negedge
  task automatic step(logic ld, logic enN, logic rl, logic [7:0] p, string tag);
    string t;
    loadEn = ld; cntEnN = enN; reloadOnTc = rl; parIn = p;
    t = (tag == "") ? tagFor(expCount, ld, enN, rl) : tag;
    @(posedge clk);
    expCount = nextCount(expCount, ld, enN, rl, p);
    @(negedge clk);
    check(t, expCount);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int firstLow;
    int secondLow;
    int seedDummy;
    seedDummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1", 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b1, 1'b0, 8'h55, "R1");

    // explicit load with counting disabled
    step(1'b1, 1'b1, 1'b0, 8'd250, "R5");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 8'h00, "R3");
    check("R2", 8'hFF);
    step(1'b0, 1'b0, 1'b0, 8'h33, "R3");   // wrap to 0
    step(1'b0, 1'b1, 1'b1, 8'h77, "R4");
    step(1'b0, 1'b1, 1'b0, 8'h12, "R4");

    // hold at terminal with reload set: no reload when disabled
    step(1'b1, 1'b0, 1'b0, 8'hFF, "R5");
    step(1'b0, 1'b1, 1'b1, 8'h20, "R4");
    // load priority over terminal reload
    step(1'b1, 1'b0, 1'b1, 8'h40, "R6");
    step(1'b1, 1'b0, 1'b0, 8'hFE, "R5");
    step(1'b0, 1'b0, 1'b1, 8'h10, "R8");
    step(1'b0, 1'b0, 1'b1, 8'h10, "R7");

    // divider: P=143 -> period 113
    step(1'b1, 1'b0, 1'b0, 8'd143, "R5");
    firstLow = -1; secondLow = -1;
    for (int k = 1; k <= 230; k++) begin
      step(1'b0, 1'b0, 1'b1, 8'd143, "R9");
      if (tcN === 1'b0) begin
        if (firstLow < 0) firstLow = k;
        else if (secondLow < 0) secondLow = k;
      end
    end
    checks++;
    if (firstLow != 112 || secondLow - firstLow != 113) begin
      failures++;
      $display("FAIL R9 first=%0d period=%0d expected first=112 period=113",
               firstLow, secondLow - firstLow);
    end

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic ld, enN, rl;
      logic [7:0] p;
      ld  = ($urandom % 16) == 0;
      enN = ($urandom % 4) == 0;
      rl  = $urandom % 2;
      p   = ($urandom % 2) ? 8'(240 + $urandom % 16) : 8'($urandom);
      step(ld, enN, rl, p, "");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule